// File: doc/BRIEF.md
# Three-Phase Gate Command Sequencer

This block turns per-phase PWM commands into gate enables for the high-side and low-side switches of three half-bridges. For each phase it takes a high-side and a low-side command. It works out which switch the phase requests, then sequences the gate enables so that the two switches of one phase are never on together. When one switch turns off, its partner cannot turn on until a programmable number of clock cycles of dead time has passed.

One mode bit selects how the inputs are read. In the six-input mode each switch has its own command. In the three-input mode the high-side command alone picks the switch, and the low-side command is ignored. Two kinds of override act after the sequencing. Each of the six gates has its own trip input, driven by overcurrent logic. A global kill input covers undervoltage, fault and enable-low conditions. Dead time and the shoot-through lockout are active in every mode.

Top module: `tri_gate_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, all six gate outputs are low.
- R2: With `map_mode`=0 (six-input mode), each phase requests as follows: `pwm_hi`=1 with `pwm_lo`=0 requests the high gate. `pwm_lo`=1 with `pwm_hi`=0 requests the low gate. Both inputs 0, or both inputs 1, request both gates off.
- R3: With `map_mode`=1 (three-input mode), a phase requests the high gate when its `pwm_hi` is 1 and the low gate when its `pwm_hi` is 0. Its `pwm_lo` has no effect on either output.
- R4: The gate outputs are registered. When the requested state of a phase changes, any gate of that phase that is no longer requested is low after the first clock edge that samples the change.
- R5: A newly requested gate goes high at the D-th clock edge after the edge that sampled the change, where D = `dead_cycles`, or D = 1 when `dead_cycles` is 0. Seen from the input change, the gate is still low after D edges and high after D+1 edges.
- R6: A further change of request while the dead-time count is running restarts the full D-cycle count.
- R7: The high and low gates of a phase are never high in the same cycle. A gate rises only when its partner was low in the previous cycle.
- R8: A high bit in `trip_hi` or `trip_lo` forces only that gate low from the next edge on. It changes neither the partner gate nor the dead-time count. Once the bit is released with the request unchanged, the gate returns at the next edge without a new dead time.
- R9: `kill` high forces all six gates low from the next edge on, whatever the other inputs are. After release, gates whose request is unchanged return at the next edge.
- R10: Each phase (bit i of every per-phase vector) is sequenced independently of the other phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_mode | input | 1 | 0 = six-input mode, 1 = three-input mode |
| dead_cycles | input | DT_W (6) | Dead time in clock cycles; 0 is treated as 1 |
| pwm_hi | input | NPH (3) | High-side command per phase |
| pwm_lo | input | NPH (3) | Low-side command per phase |
| trip_hi | input | NPH (3) | Per-phase high-gate disable from overcurrent logic |
| trip_lo | input | NPH (3) | Per-phase low-gate disable from overcurrent logic |
| kill | input | 1 | Global force-off of all gates |
| gate_hi | output | NPH (3) | High-side gate enable per phase |
| gate_lo | output | NPH (3) | Low-side gate enable per phase |

## Verification
The assertions assume that reset is applied before the first checked edge. They also assume that the input mapper never requests both gates of one phase. Beyond that they place no limits on the trip, kill or command inputs, which may change in any cycle. The stimulus changes every input half a period away from the active edge and holds `dead_cycles` and `map_mode` steady while a dead-time count is running. The only exception is the clamp test, which changes `dead_cycles` while the phases are idle.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    typedef enum logic {
        MAP_SIX   = 1'b0,
        MAP_THREE = 1'b1
    } map_mode_e;

    function automatic gate_pair_t map_request(map_mode_e mode, logic hi_in, logic lo_in);
        gate_pair_t r;
        if (mode == MAP_THREE) begin
            r.hi = hi_in;
            r.lo = ~hi_in;
        end else begin
            r.hi = hi_in & ~lo_in;
            r.lo = lo_in & ~hi_in;
        end
        return r;
    endfunction

    function automatic logic [31:0] clamp_min_one(logic [31:0] v);
        return (v == 32'd0) ? 32'd1 : v;
    endfunction

endpackage

// File: rtl/gate_input_map.sv
module gate_input_map
    import gate_seq_pkg::*;
#(
    parameter int NPH = 3
) (
    input  logic             map_mode,
    input  logic [NPH-1:0]   pwm_hi,
    input  logic [NPH-1:0]   pwm_lo,
    output gate_pair_t       req [NPH]
);

    for (genvar p = 0; p < NPH; p++) begin : g_map
        always_comb req[p] = map_request(map_mode_e'(map_mode), pwm_hi[p], pwm_lo[p]);
    end

endmodule

// File: rtl/gate_phase_seq.sv
module gate_phase_seq
    import gate_seq_pkg::*;
#(
    parameter int DT_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  gate_pair_t      req,
    input  logic [DT_W-1:0] dt_load,
    input  logic            trip_hi,
    input  logic            trip_lo,
    input  logic            kill,
    output logic            gate_hi,
    output logic            gate_lo
);

    gate_pair_t      req_q;
    logic [DT_W-1:0] cnt;
    logic            changed;
    logic            settled;

    always_comb begin
        changed = (req != req_q);
        settled = !changed && (cnt <= DT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= '0;
            cnt     <= '0;
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
        end else begin
            req_q <= req;
            if (changed)
                cnt <= dt_load;
            else if (cnt != '0)
                cnt <= cnt - DT_W'(1);
            gate_hi <= req.hi && settled && !trip_hi && !kill && !gate_lo;
            gate_lo <= req.lo && settled && !trip_lo && !kill && !gate_hi;
        end
    end

    // R7
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (rst)
        !(gate_hi && gate_lo));

    // R7
    hi_after_lo_off_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_hi) |-> !$past(gate_lo));

    // R7
    lo_after_hi_off_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_lo) |-> !$past(gate_hi));

    // R4
    change_drops_gates_chk: assert property (@(posedge clk) disable iff (rst)
        (req != req_q) |=> (!gate_hi && !gate_lo));

    // R9
    kill_off_chk: assert property (@(posedge clk) disable iff (rst)
        kill |=> (!gate_hi && !gate_lo));

    // R8
    trip_hi_off_chk: assert property (@(posedge clk) disable iff (rst)
        trip_hi |=> !gate_hi);

    // R8
    trip_lo_off_chk: assert property (@(posedge clk) disable iff (rst)
        trip_lo |=> !gate_lo);

endmodule

// File: rtl/tri_gate_sequencer.sv
module tri_gate_sequencer
    import gate_seq_pkg::*;
#(
    parameter int NPH  = 3,
    parameter int DT_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            map_mode,
    input  logic [DT_W-1:0] dead_cycles,
    input  logic [NPH-1:0]  pwm_hi,
    input  logic [NPH-1:0]  pwm_lo,
    input  logic [NPH-1:0]  trip_hi,
    input  logic [NPH-1:0]  trip_lo,
    input  logic            kill,
    output logic [NPH-1:0]  gate_hi,
    output logic [NPH-1:0]  gate_lo
);

    gate_pair_t      req [NPH];
    logic [DT_W-1:0] dt_eff;

    always_comb dt_eff = DT_W'(clamp_min_one(32'(dead_cycles)));

    gate_input_map #(.NPH(NPH)) map_i (
        .map_mode (map_mode),
        .pwm_hi   (pwm_hi),
        .pwm_lo   (pwm_lo),
        .req      (req)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        gate_phase_seq #(.DT_W(DT_W)) seq_i (
            .clk     (clk),
            .rst     (rst),
            .req     (req[p]),
            .dt_load (dt_eff),
            .trip_hi (trip_hi[p]),
            .trip_lo (trip_lo[p]),
            .kill    (kill),
            .gate_hi (gate_hi[p]),
            .gate_lo (gate_lo[p])
        );
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (gate_hi == '0 && gate_lo == '0));

endmodule

// File: tb/tri_gate_sequencer_tb.sv
module tri_gate_sequencer_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       map_mode;
    logic [5:0] dead_cycles;
    logic [2:0] pwm_hi, pwm_lo, trip_hi, trip_lo;
    logic       kill;
    logic [2:0] gate_hi, gate_lo;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tri_gate_sequencer #(.NPH(3), .DT_W(6)) dut_i (
        .clk(clk), .rst(rst), .map_mode(map_mode), .dead_cycles(dead_cycles),
        .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .trip_hi(trip_hi), .trip_lo(trip_lo),
        .kill(kill), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [2:0] eh, input logic [2:0] el);
        n_chk++;
        if (gate_hi !== eh || gate_lo !== el) begin
            n_fail++;
            $display("FAIL %s: hi/lo actual %b/%b expected %b/%b", tag, gate_hi, gate_lo, eh, el);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; map_mode = 1'b0; dead_cycles = 6'd3; kill = 1'b0;
        pwm_hi = 3'b111; pwm_lo = 3'b000; trip_hi = '0; trip_lo = '0;
        adv(3);
        chk("R1 during reset", 3'b000, 3'b000);
        pwm_hi = 3'b000;
        rst = 1'b0;
        adv(1);
        chk("R1 after reset", 3'b000, 3'b000);
    endtask

    task automatic t_six();
        pwm_hi = 3'b001; pwm_lo = 3'b000;
        adv(3); chk("R5 hi still in dead time", 3'b000, 3'b000);
        adv(1); chk("R2 hi-only drives high gate", 3'b001, 3'b000);
        pwm_lo = 3'b001;
        adv(1); chk("R2 both high gives off", 3'b000, 3'b000);
        adv(4); chk("R2 both high stays off", 3'b000, 3'b000);
        pwm_hi = 3'b000;
        adv(3); chk("R5 lo still in dead time", 3'b000, 3'b000);
        adv(1); chk("R2 lo-only drives low gate", 3'b000, 3'b001);
        pwm_hi = 3'b001; pwm_lo = 3'b000;
        adv(1); chk("R4 low gate off next edge", 3'b000, 3'b000);
        adv(2); chk("R5 gap held", 3'b000, 3'b000);
        adv(1); chk("R5 high gate after D", 3'b001, 3'b000);
    endtask

    task automatic t_phases();
        pwm_hi = 3'b011; pwm_lo = 3'b100;
        adv(1); chk("R10 phase0 unaffected", 3'b001, 3'b000);
        adv(3); chk("R10 phases 1 and 2 on", 3'b011, 3'b100);
    endtask

    task automatic t_three();
        map_mode = 1'b1; pwm_hi = 3'b000; pwm_lo = 3'b000;
        adv(1); chk("R3 hi gates drop, phase2 holds low", 3'b000, 3'b100);
        adv(3); chk("R3 low gates on", 3'b000, 3'b111);
        pwm_lo = 3'b101;
        adv(4); chk("R3 low input ignored", 3'b000, 3'b111);
        pwm_hi = 3'b010;
        adv(1); chk("R4 phase1 low off", 3'b000, 3'b101);
        adv(3); chk("R3 phase1 high on", 3'b010, 3'b101);
        pwm_lo = 3'b000;
        adv(2); chk("R3 low input ignored again", 3'b010, 3'b101);
    endtask

    task automatic t_clamp();
        map_mode = 1'b0; pwm_hi = 3'b000; pwm_lo = 3'b000;
        adv(1); chk("R2 all idle in six mode", 3'b000, 3'b000);
        adv(4);
        dead_cycles = 6'd0;
        pwm_hi = 3'b100;
        adv(1); chk("R5 zero dead time clamped", 3'b000, 3'b000);
        adv(1); chk("R5 clamped to one cycle", 3'b100, 3'b000);
    endtask

    task automatic t_restart();
        dead_cycles = 6'd4;
        pwm_hi = 3'b000; pwm_lo = 3'b100;
        adv(2); chk("R4 hi off on change", 3'b000, 3'b000);
        pwm_hi = 3'b100; pwm_lo = 3'b000;
        adv(3); chk("R6 restart mid count", 3'b000, 3'b000);
        adv(1); chk("R6 restarted count not done", 3'b000, 3'b000);
        adv(1); chk("R6 on after full restart", 3'b100, 3'b000);
    endtask

    task automatic t_trip();
        trip_hi = 3'b100;
        adv(1); chk("R8 trip forces high off", 3'b000, 3'b000);
        trip_hi = 3'b000;
        adv(1); chk("R8 release returns at once", 3'b100, 3'b000);
        trip_lo = 3'b100;
        adv(2); chk("R8 partner trip no effect", 3'b100, 3'b000);
        trip_lo = 3'b000;
    endtask

    task automatic t_kill();
        pwm_hi = 3'b101; pwm_lo = 3'b010;
        adv(6); chk("R10 setup", 3'b101, 3'b010);
        kill = 1'b1;
        adv(1); chk("R9 kill all off", 3'b000, 3'b000);
        adv(3); chk("R9 kill holds", 3'b000, 3'b000);
        kill = 1'b0;
        adv(1); chk("R9 release resumes", 3'b101, 3'b010);
    endtask

    initial begin
        t_reset();
        t_six();
        t_phases();
        t_three();
        t_clamp();
        t_restart();
        t_trip();
        t_kill();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule